// File: doc/BRIEF.md
# Credit-Gated Packet Stream Writer

This block is the transmit side of a device-to-device data stream that is flow-controlled by credits. A producer pushes 32-bit words into a local buffer. The block groups the buffered words into write packets. Each packet is a single header beat followed by its payload beats. The block launches a packet only when the credit returned by the remote consumer covers the whole payload, so a packet never stalls partway through for lack of credit. While credit is missing, producer words collect in the buffer. They drain later, when credit arrives.

Credit is counted in 4-byte words. The consumer returns a small fixed-size update that holds the cumulative number of words it has released. The writer keeps its own cumulative count of words sent. The available credit is the difference of the two, taken modulo 2^16. A configuration bit sets the largest payload to 128 bytes (32 words) or 256 bytes (64 words). A full-size packet goes out as soon as enough words and credit exist. A shorter packet, which carries everything buffered, goes out only when the flush input is high or when the buffered data has waited for a programmable number of idle cycles.

Top module: `crs_writer`

## Requirements
- R1: Every header announces a payload of at least 1 word and at most 32 words when `cfg_big` is 0, or at most 64 words when `cfg_big` is 1.
- R2: A header appears only when the available credit is at least its announced length. With too little credit, no packet starts and `credit_stall` is high while a packet is due.
- R3: `credit_avail` equals the cumulative count from the most recent accepted update, minus the words of all packets started so far, modulo 2^16. The count from an update is accepted when `crd_valid` is high at a clock edge.
- R4: When the buffer holds at least the maximum payload and credit allows, the packet length equals the maximum payload.
- R5: With fewer words than the maximum buffered and `flush` high, one packet carrying all buffered words is sent.
- R6: With `flush` low and fewer than the maximum words buffered, no packet is sent until the data has waited `cfg_idle_limit` cycles. After that, a packet carrying all buffered words is sent.
- R7: The header beat has `out_hdr` set. Its bits [11:0] hold the length in words, bits [19:12] hold a sequence number, and bits [31:20] are zero. The sequence number starts at 0 after reset and rises by one per packet, wrapping from 255 to 0.
- R8: Payload beats carry the pushed words in push order, exactly as many beats as the header announces, with `out_last` set only on the final beat.
- R9: `in_ready` is low exactly while the buffer holds DEPTH words. While `out_valid` is high and `out_ready` is low, `out_valid`, `out_hdr` and `out_data` hold steady.
- R10: A write with `in_valid` high while `in_ready` is low is dropped. It sets `overflow`, which stays set until reset.
- R11: After reset, `out_valid` is 0, `in_ready` is 1, `overflow` is 0 and `credit_avail` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_big | input | 1 | 0: 32-word maximum payload, 1: 64-word maximum payload |
| cfg_idle_limit | input | 16 | Idle cycles before a short packet is sent |
| flush | input | 1 | Allow a short packet at once |
| in_valid | input | 1 | Producer word valid |
| in_data | input | 32 | Producer word |
| in_ready | output | 1 | Buffer can accept a word |
| crd_valid | input | 1 | Credit update present |
| crd_count | input | 16 | Cumulative words released by the consumer |
| out_valid | output | 1 | Packet beat valid |
| out_ready | input | 1 | Packet beat accepted |
| out_data | output | 32 | Header or payload beat |
| out_hdr | output | 1 | Current beat is a header |
| out_last | output | 1 | Current beat is the final payload beat |
| credit_avail | output | 16 | Available credit in words |
| credit_stall | output | 1 | A packet is due but credit is insufficient |
| overflow | output | 1 | Sticky flag for a dropped write |

## Verification
The assertions assume that the consumer's cumulative count never runs ahead of the words sent by 2^15 or more, so the modulo-2^16 difference always reads as a true balance. They also assume `cfg_big` changes only while no packet is in flight and the buffer is empty. The random stimulus raises credit only when the outstanding balance is below a few hundred words. It changes `cfg_big` only at phase boundaries, after a drain with flush held high. The producer honours `in_ready` everywhere except one directed case that writes into a full buffer on purpose.

// File: rtl/crs_pkg.sv
package crs_pkg;

   typedef enum logic [1:0] {
      ST_IDLE,
      ST_HDR,
      ST_PAY
   } crs_state_e;

   localparam int unsigned HDR_LEN_LSB = 0;

endpackage

// File: rtl/crs_fifo.sv
module crs_fifo #(
   parameter int unsigned DATA_W = 32,
   parameter int unsigned DEPTH  = 128,
   parameter int unsigned CNT_W  = $clog2(DEPTH) + 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              push_valid,
   input  logic [DATA_W-1:0] push_data,
   output logic              push_ready,
   output logic              overflow,
   input  logic              pop,
   output logic [DATA_W-1:0] head,
   output logic [CNT_W-1:0]  count
);

   localparam int unsigned PTR_W = $clog2(DEPTH);

   logic [DATA_W-1:0] mem [DEPTH];
   logic [PTR_W-1:0]  wr_q, rd_q, wr_nxt, rd_nxt;
   logic [CNT_W-1:0]  cnt_q;
   logic              do_push, do_pop, ovf_q;

   generate
      if ((DEPTH & (DEPTH - 1)) == 0) begin : g_pow2
         assign wr_nxt = wr_q + 1'b1;
         assign rd_nxt = rd_q + 1'b1;
      end else begin : g_any
         assign wr_nxt = (wr_q == PTR_W'(DEPTH - 1)) ? '0 : wr_q + 1'b1;
         assign rd_nxt = (rd_q == PTR_W'(DEPTH - 1)) ? '0 : rd_q + 1'b1;
      end
   endgenerate

   assign push_ready = (cnt_q != CNT_W'(DEPTH));
   assign do_push    = push_valid && push_ready;
   assign do_pop     = pop && (cnt_q != '0);
   assign head       = mem[rd_q];
   assign count      = cnt_q;
   assign overflow   = ovf_q;

   always_ff @(posedge clk) begin
      if (do_push) mem[wr_q] <= push_data;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         wr_q  <= '0;
         rd_q  <= '0;
         cnt_q <= '0;
         ovf_q <= 1'b0;
      end else begin
         if (do_push) wr_q <= wr_nxt;
         if (do_pop)  rd_q <= rd_nxt;
         case ({do_push, do_pop})
            2'b10:   cnt_q <= cnt_q + 1'b1;
            2'b01:   cnt_q <= cnt_q - 1'b1;
            default: cnt_q <= cnt_q;
         endcase
         if (push_valid && !push_ready) ovf_q <= 1'b1;
      end
   end

   AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      overflow |=> overflow);                                  // R10
   AST_NO_POP_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
      pop |-> (cnt_q != '0));                                  // R8

endmodule

// File: rtl/crs_credit.sv
module crs_credit #(
   parameter int unsigned CRD_W = 16,
   parameter int unsigned LEN_W = 7
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             upd_valid,
   input  logic [CRD_W-1:0] upd_count,
   input  logic             take,
   input  logic [LEN_W-1:0] take_len,
   output logic [CRD_W-1:0] avail
);

   logic [CRD_W-1:0] limit_q, used_q;

   assign avail = limit_q - used_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         limit_q <= '0;
         used_q  <= '0;
      end else begin
         if (upd_valid) limit_q <= upd_count;
         if (take)      used_q  <= used_q + CRD_W'(take_len);
      end
   end

   AST_CREDIT_COVER: assert property (@(posedge clk) disable iff (!rst_n)
      take |-> (avail >= CRD_W'(take_len)));                   // R2
   AST_ZERO_TAKE: assert property (@(posedge clk) disable iff (!rst_n)
      take |-> (take_len != '0));                              // R1

endmodule

// File: rtl/crs_framer.sv
module crs_framer
   import crs_pkg::*;
#(
   parameter int unsigned DATA_W      = 32,
   parameter int unsigned CNT_W       = 8,
   parameter int unsigned CRD_W       = 16,
   parameter int unsigned IDLE_W      = 16,
   parameter int unsigned SEQ_W       = 8,
   parameter int unsigned LEN_W       = 7,
   parameter int unsigned LEN_FIELD_W = 12,
   parameter int unsigned SMALL_WORDS = 32,
   parameter int unsigned BIG_WORDS   = 64
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_big,
   input  logic [IDLE_W-1:0] cfg_idle_limit,
   input  logic              flush,
   input  logic [CNT_W-1:0]  fifo_count,
   input  logic [DATA_W-1:0] fifo_head,
   output logic              fifo_pop,
   input  logic [CRD_W-1:0]  crd_avail,
   output logic              crd_take,
   output logic [LEN_W-1:0]  crd_take_len,
   output logic              out_valid,
   input  logic              out_ready,
   output logic [DATA_W-1:0] out_data,
   output logic              out_hdr,
   output logic              out_last,
   output logic              stall
);

   crs_state_e        state_q;
   logic [LEN_W-1:0]  len_q, left_q, want_len;
   logic [SEQ_W-1:0]  seq_q;
   logic [IDLE_W-1:0] idle_q;
   logic [CNT_W-1:0]  max_cnt, want_cnt;
   logic              full_ready, idle_hit, eligible, fits, go;
   logic [DATA_W-1:0] hdr_word;

   assign max_cnt    = cfg_big ? CNT_W'(BIG_WORDS) : CNT_W'(SMALL_WORDS);
   assign full_ready = (fifo_count >= max_cnt);
   assign want_cnt   = full_ready ? max_cnt : fifo_count;
   assign want_len   = LEN_W'(want_cnt);
   assign idle_hit   = (idle_q >= cfg_idle_limit);
   assign eligible   = (state_q == ST_IDLE) && (fifo_count != '0) &&
                       (full_ready || flush || idle_hit);
   assign fits       = (crd_avail >= CRD_W'(want_len));
   assign go         = eligible && fits;
   assign stall      = eligible && !fits;

   assign crd_take     = go;
   assign crd_take_len = want_len;

   always_comb begin
      hdr_word = '0;
      hdr_word[HDR_LEN_LSB +: LEN_FIELD_W] = LEN_FIELD_W'(len_q);
      hdr_word[LEN_FIELD_W +: SEQ_W]       = seq_q;
   end

   assign out_valid = (state_q != ST_IDLE);
   assign out_hdr   = (state_q == ST_HDR);
   assign out_data  = (state_q == ST_HDR) ? hdr_word : fifo_head;
   assign out_last  = (state_q == ST_PAY) && (left_q == LEN_W'(1));
   assign fifo_pop  = (state_q == ST_PAY) && out_ready;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         len_q   <= '0;
         left_q  <= '0;
         seq_q   <= '0;
         idle_q  <= '0;
      end else begin
         if ((state_q != ST_IDLE) || (fifo_count == '0)) idle_q <= '0;
         else if (!idle_hit)                             idle_q <= idle_q + 1'b1;
         case (state_q)
            ST_IDLE: if (go) begin
               state_q <= ST_HDR;
               len_q   <= want_len;
               left_q  <= want_len;
            end
            ST_HDR: if (out_ready) state_q <= ST_PAY;
            ST_PAY: if (out_ready) begin
               left_q <= left_q - 1'b1;
               if (left_q == LEN_W'(1)) begin
                  state_q <= ST_IDLE;
                  seq_q   <= seq_q + 1'b1;
               end
            end
            default: state_q <= ST_IDLE;
         endcase
      end
   end

   AST_HOLD_BEAT: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && !out_ready) |=> (out_valid && $stable(out_data) && $stable(out_hdr))); // R9
   AST_PAY_HAS_DATA: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_PAY) |-> (fifo_count != '0));             // R8
   AST_HDR_LEN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && out_hdr) |-> ((out_data[LEN_FIELD_W-1:0] != '0) &&
                                  (out_data[LEN_FIELD_W-1:0] <= LEN_FIELD_W'(BIG_WORDS)))); // R1
   AST_LAST_ONCE: assert property (@(posedge clk) disable iff (!rst_n)
      (out_last && out_ready) |=> !out_last);                  // R8

endmodule

// File: rtl/crs_writer.sv
module crs_writer #(
   parameter int unsigned DATA_W      = 32,
   parameter int unsigned DEPTH       = 128,
   parameter int unsigned CRD_W       = 16,
   parameter int unsigned IDLE_W      = 16,
   parameter int unsigned SEQ_W       = 8,
   parameter int unsigned LEN_FIELD_W = 12,
   parameter int unsigned SMALL_WORDS = 32,
   parameter int unsigned BIG_WORDS   = 64
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_big,
   input  logic [IDLE_W-1:0] cfg_idle_limit,
   input  logic              flush,
   input  logic              in_valid,
   input  logic [DATA_W-1:0] in_data,
   output logic              in_ready,
   input  logic              crd_valid,
   input  logic [CRD_W-1:0]  crd_count,
   output logic              out_valid,
   input  logic              out_ready,
   output logic [DATA_W-1:0] out_data,
   output logic              out_hdr,
   output logic              out_last,
   output logic [CRD_W-1:0]  credit_avail,
   output logic              credit_stall,
   output logic              overflow
);

   localparam int unsigned CNT_W = $clog2(DEPTH) + 1;
   localparam int unsigned LEN_W = $clog2(BIG_WORDS) + 1;

   generate
      if (DEPTH < BIG_WORDS) begin : g_bad_depth
         $error("crs_writer: DEPTH must hold one maximum payload");
      end
      if (SMALL_WORDS > BIG_WORDS || SMALL_WORDS == 0) begin : g_bad_sizes
         $error("crs_writer: payload sizes out of order");
      end
      if (DATA_W < LEN_FIELD_W + SEQ_W) begin : g_bad_hdr
         $error("crs_writer: header fields exceed data width");
      end
      if (LEN_W > LEN_FIELD_W || LEN_W >= CRD_W) begin : g_bad_len
         $error("crs_writer: length field too narrow");
      end
   endgenerate

   logic [CNT_W-1:0]  fifo_count;
   logic [DATA_W-1:0] fifo_head;
   logic              fifo_pop, take;
   logic [LEN_W-1:0]  take_len;

   crs_fifo #(
      .DATA_W (DATA_W),
      .DEPTH  (DEPTH),
      .CNT_W  (CNT_W)
   ) u_fifo (
      .clk        (clk),
      .rst_n      (rst_n),
      .push_valid (in_valid),
      .push_data  (in_data),
      .push_ready (in_ready),
      .overflow   (overflow),
      .pop        (fifo_pop),
      .head       (fifo_head),
      .count      (fifo_count)
   );

   crs_credit #(
      .CRD_W (CRD_W),
      .LEN_W (LEN_W)
   ) u_credit (
      .clk       (clk),
      .rst_n     (rst_n),
      .upd_valid (crd_valid),
      .upd_count (crd_count),
      .take      (take),
      .take_len  (take_len),
      .avail     (credit_avail)
   );

   crs_framer #(
      .DATA_W      (DATA_W),
      .CNT_W       (CNT_W),
      .CRD_W       (CRD_W),
      .IDLE_W      (IDLE_W),
      .SEQ_W       (SEQ_W),
      .LEN_W       (LEN_W),
      .LEN_FIELD_W (LEN_FIELD_W),
      .SMALL_WORDS (SMALL_WORDS),
      .BIG_WORDS   (BIG_WORDS)
   ) u_framer (
      .clk            (clk),
      .rst_n          (rst_n),
      .cfg_big        (cfg_big),
      .cfg_idle_limit (cfg_idle_limit),
      .flush          (flush),
      .fifo_count     (fifo_count),
      .fifo_head      (fifo_head),
      .fifo_pop       (fifo_pop),
      .crd_avail      (credit_avail),
      .crd_take       (take),
      .crd_take_len   (take_len),
      .out_valid      (out_valid),
      .out_ready      (out_ready),
      .out_data       (out_data),
      .out_hdr        (out_hdr),
      .out_last       (out_last),
      .stall          (credit_stall)
   );

   AST_FULL_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
      (fifo_count == CNT_W'(DEPTH)) |-> !in_ready);            // R9
   AST_NO_LOSS_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
      (credit_stall) |-> !out_valid);                          // R2

endmodule

// File: tb/crs_writer_tb.sv
`timescale 1ns/1ps
module crs_writer_tb;

   localparam int DEPTH = 128;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cfg_big = 1'b0;
   logic [15:0] cfg_idle_limit = 16'd1000;
   logic        flush = 1'b0;
   logic        in_valid = 1'b0;
   logic [31:0] in_data = '0;
   logic        in_ready;
   logic        crd_valid = 1'b0;
   logic [15:0] crd_count = '0;
   logic        out_valid;
   logic        out_ready = 1'b0;
   logic [31:0] out_data;
   logic        out_hdr, out_last;
   logic [15:0] credit_avail;
   logic        credit_stall, overflow;

   always #10 clk = ~clk;

   crs_writer u_dut (
      .clk(clk), .rst_n(rst_n), .cfg_big(cfg_big), .cfg_idle_limit(cfg_idle_limit),
      .flush(flush), .in_valid(in_valid), .in_data(in_data), .in_ready(in_ready),
      .crd_valid(crd_valid), .crd_count(crd_count), .out_valid(out_valid),
      .out_ready(out_ready), .out_data(out_data), .out_hdr(out_hdr), .out_last(out_last),
      .credit_avail(credit_avail), .credit_stall(credit_stall), .overflow(overflow)
   );

   int tests = 0;
   int fails = 0;

   logic [31:0] expq[$];
   int          lens[$];
   int          hdr_cnt = 0;
   int          left = 0;
   logic [7:0]  exp_seq = '0;
   logic [15:0] granted = '0;
   logic [15:0] sent = '0;
   logic [15:0] cum = '0;
   logic        prev_hold = 1'b0;
   logic [31:0] prev_data = '0;
   logic        prev_hdr = 1'b0;
   logic [31:0] wcnt = 32'h1000;

   task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
      tests++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   function automatic int max_words(input logic big);
      return big ? 64 : 32;
   endfunction

   always @(negedge clk) begin
      if (rst_n) begin
         if (prev_hold)
            chk(out_valid && out_data == prev_data && out_hdr == prev_hdr,
                "R9 beat hold", out_data, prev_data);
         prev_hold = out_valid && !out_ready;
         prev_data = out_data;
         prev_hdr  = out_hdr;
         if (in_valid && in_ready) expq.push_back(in_data);
         if (out_valid && out_ready) begin
            if (left == 0) begin
               automatic int ln = int'(out_data[11:0]);
               automatic logic [15:0] bal = granted - sent;
               chk(out_hdr, "R7 header flag", out_hdr, 1);
               chk(ln >= 1 && ln <= max_words(cfg_big), "R1 length range", ln, max_words(cfg_big));
               chk(out_data[19:12] == exp_seq, "R7 sequence", out_data[19:12], exp_seq);
               chk(out_data[31:20] == 0, "R7 reserved bits", out_data[31:20], 0);
               chk(ln <= int'(bal), "R2 credit covers packet", ln, bal);
               left = ln;
               sent = sent + 16'(ln);
               lens.push_back(ln);
               hdr_cnt++;
               exp_seq = exp_seq + 1'b1;
            end else begin
               automatic logic [31:0] ew = (expq.size() > 0) ? expq.pop_front() : 32'hX;
               chk(!out_hdr, "R8 payload flag", out_hdr, 0);
               chk(out_data === ew, "R8 payload order", out_data, ew);
               chk(out_last == (left == 1), "R8 last marker", out_last, left == 1);
               left--;
            end
         end
         if (crd_valid) granted = crd_count;
      end
   end

   task automatic cyc(input int n);
      for (int i = 0; i < n; i++) begin
         @(posedge clk);
         #1;
      end
   endtask

   task automatic do_reset();
      rst_n = 1'b0;
      in_valid = 1'b0;
      crd_valid = 1'b0;
      flush = 1'b0;
      out_ready = 1'b0;
      cyc(3);
      expq.delete();
      lens.delete();
      hdr_cnt = 0;
      left = 0;
      exp_seq = '0;
      granted = '0;
      sent = '0;
      cum = '0;
      prev_hold = 1'b0;
      rst_n = 1'b1;
      cyc(1);
   endtask

   task automatic push_n(input int n);
      for (int i = 0; i < n; i++) begin
         in_valid = 1'b1;
         in_data = wcnt;
         wcnt++;
         cyc(1);
      end
      in_valid = 1'b0;
   endtask

   task automatic grant(input int inc);
      cum = cum + 16'(inc);
      crd_valid = 1'b1;
      crd_count = cum;
      cyc(1);
      crd_valid = 1'b0;
   endtask

   initial begin
      for (int c = 0; c < 200000; c++) @(posedge clk);
      fails++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", tests, 0);
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

   initial begin
      void'($urandom(32'd20240611));
      do_reset();
      // R11 reset state
      chk(out_valid == 0, "R11 out_valid", out_valid, 0);
      chk(in_ready == 1, "R11 in_ready", in_ready, 1);
      chk(overflow == 0, "R11 overflow", overflow, 0);
      chk(credit_avail == 0, "R11 credit_avail", credit_avail, 0);

      // R2: no credit, nothing leaves
      out_ready = 1'b1;
      push_n(40);
      flush = 1'b1;
      cyc(20);
      chk(hdr_cnt == 0, "R2 stall without credit", hdr_cnt, 0);
      chk(credit_stall == 1, "R2 stall flag", credit_stall, 1);

      // R3 credit arrives
      grant(100);
      chk(credit_avail == 100, "R3 credit after update", credit_avail, 100);
      cyc(100);
      chk(hdr_cnt == 2, "R5 packet count", hdr_cnt, 2);
      chk(lens.size() > 0 && lens[0] == 32, "R4 full small packet", lens.size() > 0 ? lens[0] : -1, 32);
      chk(lens.size() > 1 && lens[1] == 8, "R5 flushed short packet", lens.size() > 1 ? lens[1] : -1, 8);
      chk(credit_avail == 60, "R3 credit after use", credit_avail, 60);
      flush = 1'b0;

      // R4 big payload, blocked by 60 < 64
      cfg_big = 1'b1;
      push_n(70);
      cyc(5);
      chk(hdr_cnt == 2, "R2 partial credit blocks", hdr_cnt, 2);
      grant(100);
      cyc(100);
      chk(hdr_cnt == 3 && lens[2] == 64, "R4 full big packet", lens[lens.size()-1], 64);
      flush = 1'b1;
      cyc(30);
      flush = 1'b0;
      chk(hdr_cnt == 4 && lens[3] == 6, "R5 flush remainder", lens[lens.size()-1], 6);

      // R6 idle timeout
      cfg_idle_limit = 16'd20;
      cyc(2);
      push_n(1);
      cyc(10);
      chk(hdr_cnt == 4, "R6 no packet before timeout", hdr_cnt, 4);
      cyc(30);
      chk(hdr_cnt == 5 && lens[4] == 1, "R6 packet after timeout", lens[lens.size()-1], 1);

      // R10 overflow and R9 full buffer
      do_reset();
      cfg_big = 1'b1;
      cfg_idle_limit = 16'd1000;
      push_n(DEPTH);
      chk(in_ready == 0, "R9 full deasserts ready", in_ready, 0);
      chk(overflow == 0, "R10 no early overflow", overflow, 0);
      in_valid = 1'b1;
      in_data = 32'hDEAD_BEEF;
      cyc(1);
      in_valid = 1'b0;
      chk(overflow == 1, "R10 overflow set", overflow, 1);
      cyc(5);
      chk(overflow == 1, "R10 overflow sticky", overflow, 1);
      grant(1000);
      out_ready = 1'b1;
      flush = 1'b1;
      cyc(400);
      chk(hdr_cnt == 2, "R10 dropped word not sent", hdr_cnt, 2);
      chk(expq.size() == 0, "R10 queue drained", expq.size(), 0);

      // random phases
      do_reset();
      for (int ph = 0; ph < 4; ph++) begin
         cfg_big = ph[0];
         cfg_idle_limit = 16'($urandom_range(5, 60));
         for (int c = 0; c < 5000; c++) begin
            in_valid = ($urandom_range(0, 1) == 1) && in_ready;
            in_data = $urandom();
            out_ready = ($urandom_range(0, 9) < 7);
            flush = ($urandom_range(0, 19) == 0);
            if (16'(cum - sent) < 16'd300 && $urandom_range(0, 7) == 0) begin
               cum = cum + 16'($urandom_range(1, 200));
               crd_valid = 1'b1;
               crd_count = cum;
            end else begin
               crd_valid = 1'b0;
            end
            cyc(1);
         end
         in_valid = 1'b0;
         crd_valid = 1'b0;
         out_ready = 1'b1;
         flush = 1'b1;
         grant(400);
         cyc(400);
         flush = 1'b0;
         chk(expq.size() == 0 && left == 0, "R8 phase drained", expq.size(), 0);
      end
      chk(hdr_cnt > 256, "R7 sequence wrap exercised", hdr_cnt, 257);

      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

endmodule